// File: doc/BRIEF.md
# Display start-address scan controller

This block generates raster timing for a 320 x 200 picture and the frame-buffer scan address that goes with it. Each clock is one group of four pixels. The controller walks a 16-bit scan address through the visible area. The address rises by one per pixel group, and each row begins 80 addresses after the row above it. A host scrolls the picture by changing where the scan starts. Adding 80 to the start moves the image up one line. Adding 1 moves it sideways by four pixels.

The host reaches the block through three ports selected by `host_sel`:

- **Index port.** Selects an internal register.
- **Data port.** Reads or writes the selected register. Index 0x0C holds the high byte of the start address and index 0x0D holds the low byte.
- **Status port.** Reports vertical retrace and display blanking.

Start-address writes land in a shadow pair. The scan takes the shadow value only when vertical retrace begins, so a split high/low update never tears a frame.

Top module: `scan_start_ctrl`

## Requirements
- R1: After reset the index register, both start-address shadow bytes and the active start address are zero, and the first frame scans from address 0 with `disp_en` high in the first cycle.
- R2: A write with `host_sel`=0 loads the index register, and `host_sel`=0 reads it back. With `host_sel`=1 the data port reads and writes the register the index selects: 0x0C is the start high byte and 0x0D is the start low byte.
- R3: A data-port write while the index holds any value other than 0x0C or 0x0D changes neither shadow byte. A data-port read at such an index returns 0.
- R4: The active start address is loaded from the shadow pair on the clock edge where `vsync` rises. A shadow write on that same edge is not included. The loaded value governs the next frame, which begins at row 0, column 0.
- R5: At every active pixel group, `scan_addr` equals start + 80*row + column, taken modulo 65536.
- R6: `disp_en` is high exactly when the column is below 80 and the row is below 200. A line is H_TOTAL clocks and a frame is V_TOTAL lines.
- R7: `hsync` is high for H_SYNC clocks starting at column 80+H_FP. `vsync` is high for V_SYNC lines starting at row 200+V_FP. Neither sync is ever high while `disp_en` is high.
- R8: A read with `host_sel`=2 returns status. Bit 3 is 1 during vertical sync. Bit 0 is 1 whenever `disp_en` is low. All other bits are 0.
- R9: A start address near the top of the space wraps: start 0xFFF0 gives address 0x0000 at column 16 of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | 0 index, 1 data, 2 status |
| host_wr | input | 1 | Write strobe for index or data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Visible-area enable |
| scan_addr | output | 16 | Frame-buffer scan address |

## Verification
A host write to the low start byte can land on the same clock edge that loads the active start at the beginning of vertical retrace. The bench arranges this on purpose. It writes the index early, then times the data write against its own position counter so that the write hits exactly that edge. It then requires the next frame to open at the old start value while the data port already reads back the new byte. Random writes at random moments are judged against a bench-side model of the shadow and active starts, and every visible pixel group is compared with the address that model predicts.

// File: rtl/scan_start_ctrl.sv
module scan_start_ctrl #(
  parameter int H_ACTIVE    = 80,
  parameter int H_FP        = 4,
  parameter int H_SYNC      = 12,
  parameter int H_BP        = 4,
  parameter int V_ACTIVE    = 200,
  parameter int V_FP        = 3,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 5,
  parameter int LINE_STRIDE = 80,
  parameter logic [7:0] IDX_HI = 8'h0C,
  parameter logic [7:0] IDX_LO = 8'h0D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  host_sel,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        hsync,
  output logic        vsync,
  output logic        disp_en,
  output logic [15:0] scan_addr
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS   = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACTIVE + V_FP + V_SYNC);
  localparam logic [VW-1:0] VS_PRE  = VW'(V_ACTIVE + V_FP - 1);
  localparam logic [15:0]   STRIDE  = 16'(LINE_STRIDE);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [7:0]    idx, sh_hi, sh_lo;
  logic [15:0]   start_act, row_base;

  wire line_end  = hcnt == H_LAST;
  wire frame_end = line_end && vcnt == V_LAST;
  wire load_now  = line_end && vcnt == VS_PRE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      if (line_end) vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_act <= '0;
      row_base  <= '0;
    end else begin
      if (load_now) start_act <= {sh_hi, sh_lo};
      if (frame_end) row_base <= start_act;
      else if (line_end && vcnt < V_VIS) row_base <= row_base + STRIDE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx   <= '0;
      sh_hi <= '0;
      sh_lo <= '0;
    end else if (host_wr) begin
      if (host_sel == 2'd0) idx <= host_wdata;
      else if (host_sel == 2'd1) begin
        if (idx == IDX_HI) sh_hi <= host_wdata;
        if (idx == IDX_LO) sh_lo <= host_wdata;
      end
    end

  assign disp_en   = hcnt < H_VIS && vcnt < V_VIS;
  assign hsync     = hcnt >= HS_BEG && hcnt < HS_END;
  assign vsync     = vcnt >= VS_BEG && vcnt < VS_END;
  assign scan_addr = row_base + 16'(hcnt);

  always_comb
    case (host_sel)
      2'd0:    host_rdata = idx;
      2'd1:    host_rdata = (idx == IDX_HI) ? sh_hi : (idx == IDX_LO) ? sh_lo : 8'h00;
      2'd2:    host_rdata = {4'b0000, vsync, 2'b00, ~disp_en};
      default: host_rdata = 8'h00;
    endcase
endmodule

// File: rtl/scan_start_chk.sv
module scan_start_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  host_sel,
  input logic [7:0]  host_rdata,
  input logic        hsync,
  input logic        vsync,
  input logic        disp_en,
  input logic [15:0] scan_addr,
  input logic [15:0] start_act
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  p_scan_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen && disp_en && $past(disp_en) |-> scan_addr == $past(scan_addr) + 16'd1);

  p_start_at_retrace_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$stable(start_act) |-> $rose(vsync));

  p_blank_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> !hsync && !vsync);

  p_status_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel == 2'd2 |-> host_rdata[3] == vsync && host_rdata[0] == !disp_en
                         && host_rdata[7:4] == 4'h0 && host_rdata[2:1] == 2'b00);
endmodule

bind scan_start_ctrl scan_start_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rdata(host_rdata),
  .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .scan_addr(scan_addr),
  .start_act(start_act)
);

// File: tb/scan_start_ctrl_bench.sv
module scan_start_ctrl_bench;
  localparam int HA = 80, HFP = 4, HS = 12, HBP = 4;
  localparam int VA = 200, VFP = 3, VS = 2, VBP = 5;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int TOT = HT * VT;
  localparam int LOAD_POS = (VA + VFP) * HT;

  logic clk = 0, rst_n = 0, host_wr = 0;
  logic [1:0] host_sel = 2'd2;
  logic [7:0] host_wdata = 0, host_rdata;
  logic hsync, vsync, disp_en;
  logic [15:0] scan_addr;

  int n = 0, checks = 0, errors = 0;
  bit mon_on = 0, done = 0;
  logic [15:0] mstart = 0, mframe = 0;
  logic [7:0] mhi = 0, mlo = 0, midx = 0;

  always #5 clk = ~clk;

  scan_start_ctrl #(.H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
                    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP)) u_scan_start_ctrl (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .hsync(hsync),
    .vsync(vsync), .disp_en(disp_en), .scan_addr(scan_addr));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model of raster position, shadow pair and active start
  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; mstart = 0; mframe = 0; mhi = 0; mlo = 0; midx = 0;
    end else begin
      n++;
      if (n % TOT == LOAD_POS) mstart = {mhi, mlo};
      if (n % TOT == 0) mframe = mstart;
      if (host_wr && host_sel == 2'd0) midx = host_wdata;
      else if (host_wr && host_sel == 2'd1) begin
        if (midx == 8'h0C) mhi = host_wdata;
        if (midx == 8'h0D) mlo = host_wdata;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && mon_on) begin
      int p, col, row;
      bit ede, ehs, evs;
      p = n % TOT; col = p % HT; row = p / HT;
      ede = col < HA && row < VA;
      ehs = col >= HA + HFP && col < HA + HFP + HS;
      evs = row >= VA + VFP && row < VA + VFP + VS;
      chk("R6 disp_en", disp_en, ede);
      chk("R7 hsync", hsync, ehs);
      chk("R7 vsync", vsync, evs);
      if (ede) chk("R5 scan_addr", scan_addr, 16'(mframe + 16'(80 * row + col)));
      if (host_sel == 2'd2) chk("R8 status", host_rdata, {4'b0, evs, 2'b0, !ede});
    end
  end

  task automatic host_write(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0; host_sel = 2'd2;
  endtask

  task automatic host_read(logic [1:0] sel, logic [7:0] exp, string tag);
    @(negedge clk);
    host_sel = sel;
    #1 chk(tag, host_rdata, exp);
    host_sel = 2'd2;
  endtask

  task automatic wait_pos(int target);
    do @(negedge clk); while ((n % TOT) != target);
  endtask

  function automatic logic [7:0] exp_data();
    return (midx == 8'h0C) ? mhi : (midx == 8'h0D) ? mlo : 8'h00;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1217));
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 scan_addr after reset", scan_addr, 16'h0000);
    chk("R1 disp_en after reset", disp_en, 1'b1);
    mon_on = 1;
    host_read(2'd0, 8'h00, "R1 index reset");
    host_write(2'd0, 8'h0C);
    host_read(2'd1, 8'h00, "R1 high byte reset");
    host_write(2'd0, 8'h0D);
    host_read(2'd1, 8'h00, "R1 low byte reset");
    // R2 programming
    host_write(2'd0, 8'h0C);
    host_write(2'd1, 8'h12);
    host_read(2'd0, 8'h0C, "R2 index readback");
    host_read(2'd1, 8'h12, "R2 high byte readback");
    host_write(2'd0, 8'h0D);
    host_write(2'd1, 8'h34);
    host_read(2'd1, 8'h34, "R2 low byte readback");
    // R3 unknown index
    host_write(2'd0, 8'h05);
    host_write(2'd1, 8'h77);
    host_read(2'd1, 8'h00, "R3 unknown index read");
    host_write(2'd0, 8'h0C);
    host_read(2'd1, 8'h12, "R3 high byte untouched");
    host_write(2'd0, 8'h0D);
    host_read(2'd1, 8'h34, "R3 low byte untouched");
    // R4 collision: low-byte write on the load edge
    wait_pos(LOAD_POS - 2);
    host_write(2'd1, 8'hAB);
    host_read(2'd1, 8'hAB, "R2 low byte after collision");
    wait_pos(0);
    #1 chk("R4 frame start ignores colliding write", scan_addr, 16'h1234);
    // R9 wrap
    host_write(2'd0, 8'h0C);
    host_write(2'd1, 8'hFF);
    host_write(2'd0, 8'h0D);
    host_write(2'd1, 8'hF0);
    wait_pos(0);
    #1 chk("R9 frame start near top", scan_addr, 16'hFFF0);
    wait_pos(16);
    #1 chk("R9 wrap to zero", scan_addr, 16'h0000);
    wait_pos(HT);
    #1 chk("R5 second row after wrap", scan_addr, 16'h0040);
    // random host traffic
    while (n < 5 * TOT) begin
      case ($urandom % 4)
        0: begin
          int r = $urandom % 3;
          host_write(2'd0, r == 0 ? 8'h0C : r == 1 ? 8'h0D : 8'($urandom));
        end
        1: host_write(2'd1, 8'($urandom));
        2: host_read(2'd1, exp_data(), "R2 random data read");
        default: host_read(2'd0, midx, "R2 random index read");
      endcase
      repeat ($urandom % 2000) @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule